// File: doc/BRIEF.md
# Resistive Touch Scan Host Controller

This block is the host-side serial master for a four-wire resistive touch converter. It sits idle with the chip select released until the active-low pen line reports a touch. It then lowers chip select and runs two conversion frames back to back, first X and then Y. Each frame has 24 serial clocks, sent as three bursts of eight. The first burst shifts out a control byte that selects the axis, 12-bit resolution, the ratiometric reference and the power setting that keeps the pen interrupt enabled. The result is picked out of the returned bit stream.

The serial clock high time, low time, chip-select setup time, gap between bursts and release time between scans are parameters counted in system clock cycles. After the Y frame the pen line is sampled once more. If the panel is still touched, both coordinates are presented together with a one-cycle valid strobe. If the pen has lifted, the pair is dropped.

The controller is built around one state machine:
- States: `ST_IDLE`, `ST_SETUP`, `ST_LOW`, `ST_HIGH`, `ST_GAP`, `ST_CHECK` and `ST_REST`.
- Transitions:
  - IDLE→SETUP when the pen is down.
  - SETUP→LOW when the setup timer expires.
  - LOW→HIGH when the low timer expires.
  - HIGH→LOW inside a burst.
  - HIGH→GAP at the end of a burst, or at the end of the X frame.
  - HIGH→CHECK at the end of the Y frame.
  - GAP→LOW when the gap timer expires.
  - CHECK→REST always.
  - REST→IDLE when the rest timer expires.

Top module: `tscan_host`

## Requirements
- R1: After reset, and while `pen_n` stays high in idle, `cs_n` is 1, `sclk` is 0, `pos_valid` is 0, and `x_pos`/`y_pos` are 0.
- R2: `cs_n` goes low one cycle after `pen_n` is sampled low in idle. The first `sclk` rise comes SETUP_CYC+LO_CYC cycles after `cs_n` falls.
- R3: Within a scan, every `sclk` high phase lasts HI_CYC cycles. Every low phase inside a burst lasts LO_CYC cycles. After each eighth rise the low phase lasts GAP_CYC+LO_CYC cycles.
- R4: Control bytes go out MSB first on `sdi`, one bit per rise, on rises 1..8 of each frame:
  - X frame: 8'b1101_0000. This is start bit 1, channel 101, resolution bit 0 (12-bit), reference bit 0 (ratiometric) and power field 00.
  - Y frame: 8'b1001_0000, which differs only in channel 001.
  - `sdi` is 0 on rises 9..24, and `sdi` never changes while `sclk` is high.
- R5: The result is the `sdo` value sampled at rises 10..21 of a frame, MSB first. `sdo` at every other rise has no effect on the reported coordinate.
- R6: One scan is an X frame followed by a Y frame under a single low period of `cs_n`, for 48 rises in total.
- R7: `pen_n` is ignored while frames run. A lift or bounce during a frame neither stops nor shortens the scan.
- R8: If `pen_n` is low in the check cycle after the Y frame:
  - `x_pos` and `y_pos` take the new pair.
  - `pos_valid` pulses for exactly one cycle, while `cs_n` is already high.
  - If `pen_n` is high in that cycle instead, no pulse occurs and `x_pos`/`y_pos` keep their previous values.
- R9: Between scans, `cs_n` stays high for at least REST_CYC cycles. With the pen held down it stays high for exactly REST_CYC+1 cycles, and then the next scan starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pen_n | input | 1 | Touch detect from the converter, low while touched |
| sdo | input | 1 | Serial data returned by the converter |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to the converter |
| sdi | output | 1 | Serial control data to the converter |
| x_pos | output | RES_W | Last accepted X result |
| y_pos | output | RES_W | Last accepted Y result |
| pos_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The assertions assume that `pen_n` and `sdo` are already synchronous to `clk`. They also assume that `sdo` changes only while `sclk` is low, as a converter that shifts on the falling edge would behave. The bench model of the converter updates `sdo` only on `sclk` falling edges, and it drives ones at every rise outside the result window. The bench changes `pen_n` only on falling edges of `clk`, so each scenario stays inside what the assertions take for granted.

// File: rtl/tscan_pkg.sv
package tscan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_LOW   = 3'd2,
        ST_HIGH  = 3'd3,
        ST_GAP   = 3'd4,
        ST_CHECK = 3'd5,
        ST_REST  = 3'd6
    } tscan_state_e;

    typedef enum logic {
        AX_X = 1'b0,
        AX_Y = 1'b1
    } tscan_axis_e;

    localparam int CTRL_W = 8;

    // Fields of the control byte, MSB first on the wire
    localparam logic       START_BIT  = 1'b1;
    localparam logic [2:0] CHAN_X     = 3'b101;
    localparam logic [2:0] CHAN_Y     = 3'b001;
    localparam logic       RES_12BIT  = 1'b0;
    localparam logic       REF_RATIO  = 1'b0;
    localparam logic [1:0] PWR_PEN_ON = 2'b00;

    function automatic logic [CTRL_W-1:0] ctrl_byte(input tscan_axis_e ax);
        logic [2:0] ch;
        ch = (ax == AX_X) ? CHAN_X : CHAN_Y;
        return {START_BIT, ch, RES_12BIT, REF_RATIO, PWR_PEN_ON};
    endfunction

endpackage

// File: rtl/tscan_timer.sv
module tscan_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             zero
);

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/tscan_tx.sv
module tscan_tx
    import tscan_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  tscan_axis_e      axis,
    input  logic [IDX_W-1:0] bit_idx,
    output logic             bit_o
);

    logic [CTRL_W-1:0] cbyte;

    always_comb begin
        cbyte = ctrl_byte(axis);
        bit_o = 1'b0;
        for (int i = 0; i < CTRL_W; i++) begin
            if (bit_idx == IDX_W'(i)) begin
                bit_o = cbyte[CTRL_W-1-i];
            end
        end
    end

endmodule

// File: rtl/tscan_rx.sv
module tscan_rx #(
    parameter int RES_W     = 12,
    parameter int IDX_W     = 5,
    parameter int FIRST_IDX = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             sdo,
    input  logic             commit_x,
    input  logic             commit_y,
    output logic [RES_W-1:0] x_hold,
    output logic [RES_W-1:0] y_hold
);

    localparam int LAST_IDX = FIRST_IDX + RES_W - 1;

    logic [RES_W-1:0] shreg;
    logic             in_win;

    assign in_win = (bit_idx >= IDX_W'(FIRST_IDX)) && (bit_idx <= IDX_W'(LAST_IDX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            x_hold <= '0;
            y_hold <= '0;
        end else begin
            if (cap_en && in_win) begin
                shreg <= {shreg[RES_W-2:0], sdo};
            end
            if (commit_x) begin
                x_hold <= shreg;
            end
            if (commit_y) begin
                y_hold <= shreg;
            end
        end
    end

endmodule

// File: rtl/tscan_host.sv
module tscan_host
    import tscan_pkg::*;
#(
    parameter int HI_CYC    = 10,
    parameter int LO_CYC    = 10,
    parameter int SETUP_CYC = 5,
    parameter int GAP_CYC   = 8,
    parameter int REST_CYC  = 16,
    parameter int RES_W     = 12,
    parameter int BURST     = 8,
    parameter int NBURST    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pen_n,
    input  logic             sdo,
    output logic             cs_n,
    output logic             sclk,
    output logic             sdi,
    output logic [RES_W-1:0] x_pos,
    output logic [RES_W-1:0] y_pos,
    output logic             pos_valid
);

    localparam int FRAME_LEN = BURST * NBURST;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int FIRST_IDX = BURST + 1;
    localparam int MAX_PH    = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
    localparam int MAX_AUX   = (SETUP_CYC > GAP_CYC) ? SETUP_CYC : GAP_CYC;
    localparam int MAX_A2    = (MAX_PH > MAX_AUX) ? MAX_PH : MAX_AUX;
    localparam int MAX_CYC   = (MAX_A2 > REST_CYC) ? MAX_A2 : REST_CYC;
    localparam int TMR_W     = $clog2(MAX_CYC + 1);

    tscan_state_e     state_q, state_d;
    tscan_axis_e      axis_q;
    logic [IDX_W-1:0] bit_idx_q;
    logic             tmr_zero, tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             frame_last, burst_end, adv, cap_en;
    logic             tx_bit;
    logic [RES_W-1:0] x_hold, y_hold;

    assign frame_last = (bit_idx_q == IDX_W'(FRAME_LEN - 1));
    assign burst_end  = ((int'(bit_idx_q) % BURST) == (BURST - 1));
    assign adv        = (state_q == ST_HIGH) && tmr_zero;
    assign cap_en     = (state_q == ST_LOW) && tmr_zero;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!pen_n) state_d = ST_SETUP;
            ST_SETUP: if (tmr_zero) state_d = ST_LOW;
            ST_LOW:   if (tmr_zero) state_d = ST_HIGH;
            ST_HIGH: begin
                if (tmr_zero) begin
                    if (frame_last) begin
                        state_d = (axis_q == AX_Y) ? ST_CHECK : ST_GAP;
                    end else if (burst_end) begin
                        state_d = ST_GAP;
                    end else begin
                        state_d = ST_LOW;
                    end
                end
            end
            ST_GAP:   if (tmr_zero) state_d = ST_LOW;
            ST_CHECK: state_d = ST_REST;
            ST_REST:  if (tmr_zero) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Phase timer reload on every state change
    assign tmr_load = (state_d != state_q);

    always_comb begin
        unique case (state_d)
            ST_SETUP: tmr_val = TMR_W'(SETUP_CYC - 1);
            ST_LOW:   tmr_val = TMR_W'(LO_CYC - 1);
            ST_HIGH:  tmr_val = TMR_W'(HI_CYC - 1);
            ST_GAP:   tmr_val = TMR_W'(GAP_CYC - 1);
            ST_REST:  tmr_val = TMR_W'(REST_CYC - 1);
            default:  tmr_val = '0;
        endcase
    end

    tscan_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    tscan_tx #(.IDX_W(IDX_W)) u_tx (
        .axis    (axis_q),
        .bit_idx (bit_idx_q),
        .bit_o   (tx_bit)
    );

    tscan_rx #(.RES_W(RES_W), .IDX_W(IDX_W), .FIRST_IDX(FIRST_IDX)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .bit_idx  (bit_idx_q),
        .sdo      (sdo),
        .commit_x (adv && frame_last && (axis_q == AX_X)),
        .commit_y (adv && frame_last && (axis_q == AX_Y)),
        .x_hold   (x_hold),
        .y_hold   (y_hold)
    );

    // Frame position, axis and presented pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx_q <= '0;
            axis_q    <= AX_X;
            pos_valid <= 1'b0;
            x_pos     <= '0;
            y_pos     <= '0;
        end else begin
            if (state_q == ST_IDLE) begin
                bit_idx_q <= '0;
                axis_q    <= AX_X;
            end else if (adv) begin
                if (frame_last) begin
                    bit_idx_q <= '0;
                    axis_q    <= AX_Y;
                end else begin
                    bit_idx_q <= bit_idx_q + 1'b1;
                end
            end
            pos_valid <= (state_q == ST_CHECK) && !pen_n;
            if ((state_q == ST_CHECK) && !pen_n) begin
                x_pos <= x_hold;
                y_pos <= y_hold;
            end
        end
    end

    // Output decode
    always_comb begin
        cs_n = (state_q == ST_IDLE) || (state_q == ST_REST);
        sclk = (state_q == ST_HIGH);
        unique case (state_q)
            ST_SETUP, ST_LOW, ST_HIGH, ST_GAP: sdi = tx_bit;
            default:                           sdi = 1'b0;
        endcase
    end

endmodule

// File: rtl/tscan_host_chk.sv
module tscan_host_chk #(
    parameter int HI_CYC   = 10,
    parameter int LO_CYC   = 10,
    parameter int REST_CYC = 16
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic sdi,
    input logic pos_valid
);

    int hi_len, lo_len, cs_hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len    <= 0;
            lo_len    <= 0;
            cs_hi_len <= REST_CYC;
        end else begin
            if (sclk) hi_len <= (hi_len > HI_CYC) ? hi_len : hi_len + 1;
            else      hi_len <= 0;
            if (!sclk) lo_len <= (lo_len >= LO_CYC) ? lo_len : lo_len + 1;
            else       lo_len <= 0;
            if (cs_n) cs_hi_len <= (cs_hi_len >= REST_CYC) ? cs_hi_len : cs_hi_len + 1;
            else      cs_hi_len <= 0;
        end
    end

    // R1
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R3
    high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_len == HI_CYC));

    // R3
    low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> (lo_len >= LO_CYC));

    // R4
    din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdi));

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_valid |=> !pos_valid);

    // R8
    valid_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_valid |-> cs_n);

    // R9
    rest_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (cs_hi_len >= REST_CYC));

endmodule

bind tscan_host tscan_host_chk #(
    .HI_CYC   (HI_CYC),
    .LO_CYC   (LO_CYC),
    .REST_CYC (REST_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .sdi       (sdi),
    .pos_valid (pos_valid)
);

// File: tb/sim_tscan_host.sv
module sim_tscan_host;

    localparam int CLK_PERIOD = 10;
    localparam int P_HI    = 3;
    localparam int P_LO    = 2;
    localparam int P_SETUP = 5;
    localparam int P_GAP   = 4;
    localparam int P_REST  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pen_n = 1'b1;
    logic        sdo = 1'b1;
    logic        cs_n, sclk, sdi, pos_valid;
    logic [11:0] x_pos, y_pos;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tscan_host #(
        .HI_CYC(P_HI), .LO_CYC(P_LO), .SETUP_CYC(P_SETUP),
        .GAP_CYC(P_GAP), .REST_CYC(P_REST)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .pen_n(pen_n), .sdo(sdo),
        .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .x_pos(x_pos), .y_pos(y_pos), .pos_valid(pos_valid)
    );

    // Converter model: counts rises, records control bits, shifts the result out on falling edges
    logic [11:0] xv = 12'h000;
    logic [11:0] yv = 12'h000;
    int          n_rise = 0;
    int          sdi_bad = 0;
    logic [7:0]  cb0 = 8'h00;
    logic [7:0]  cb1 = 8'h00;
    logic        sclk_m = 1'b0;
    logic        cs_m = 1'b1;

    function automatic logic model_bit(input int n, input logic [11:0] a, input logic [11:0] b);
        int p;
        logic [11:0] v;
        p = (n % 24) + 1;
        v = ((n / 24) == 0) ? a : b;
        if (p >= 10 && p <= 21) return v[21-p];
        return 1'b1;
    endfunction

    always @(sclk or cs_n) begin
        if (cs_m && !cs_n) begin
            n_rise  = 0;
            sdi_bad = 0;
            cb0     = 8'h00;
            cb1     = 8'h00;
            sdo     = model_bit(0, xv, yv);
        end
        if (!cs_n && sclk && !sclk_m) begin
            if ((n_rise % 24) < 8) begin
                if (n_rise < 24) cb0 = {cb0[6:0], sdi};
                else             cb1 = {cb1[6:0], sdi};
            end else if (sdi) begin
                sdi_bad++;
            end
            n_rise++;
        end
        if (!cs_n && !sclk && sclk_m) begin
            sdo = model_bit(n_rise, xv, yv);
        end
        sclk_m = sclk;
        cs_m   = cs_n;
    end

    // Phase monitor, sampled on falling clock edges
    int hrun = 0, lrun = 0, csh = 0, last_rest = 0;
    int hi_runs = 0, hi_bad = 0, lo_first = 0, lo_gap = 0, lo_bit = 0, lo_other = 0;
    int vcount = 0, v_wide = 0;
    logic v_prev = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            hrun = 0; lrun = 0; csh = 0;
        end else if (cs_n) begin
            hrun = 0; lrun = 0; csh++;
        end else begin
            if (csh != 0) begin
                last_rest = csh; csh = 0;
                hi_runs = 0; hi_bad = 0; lo_first = 0; lo_gap = 0; lo_bit = 0; lo_other = 0;
            end
            if (sclk) begin
                if (lrun != 0) begin
                    if (lrun == P_SETUP + P_LO)    lo_first++;
                    else if (lrun == P_GAP + P_LO) lo_gap++;
                    else if (lrun == P_LO)         lo_bit++;
                    else                           lo_other++;
                    lrun = 0;
                end
                hrun++;
            end else begin
                if (hrun != 0) begin
                    hi_runs++;
                    if (hrun != P_HI) hi_bad++;
                    hrun = 0;
                end
                lrun++;
            end
        end
        if (pos_valid) begin
            vcount++;
            if (v_prev) v_wide++;
        end
        v_prev = pos_valid;
    end

    task automatic check_eq(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_valid(input string req);
        int t;
        for (t = 0; t < 3000; t++) begin
            @(negedge clk);
            if (pos_valid) break;
        end
        check_eq(req, "pos_valid seen", longint'(t < 3000), 1);
    endtask

    task automatic wait_released();
        int q = 0;
        while (q < 20) begin
            @(negedge clk);
            if (cs_n) q++; else q = 0;
        end
    endtask

    task automatic check_frame_shape();
        check_eq("R6", "rises per scan", n_rise, 48);
        check_eq("R4", "X control byte", cb0, 8'hD0);
        check_eq("R4", "Y control byte", cb1, 8'h90);
        check_eq("R4", "sdi high after control byte", sdi_bad, 0);
        check_eq("R3", "high phases", hi_runs, 48);
        check_eq("R3", "high phases of wrong width", hi_bad, 0);
        check_eq("R2", "setup low phase", lo_first, 1);
        check_eq("R3", "burst gap phases", lo_gap, 5);
        check_eq("R3", "bit low phases", lo_bit, 42);
        check_eq("R3", "odd low phases", lo_other, 0);
    endtask

    // R1: reset state and idle with pen up
    task automatic t_reset();
        @(negedge clk);
        check_eq("R1", "cs_n", cs_n, 1);
        check_eq("R1", "sclk", sclk, 0);
        check_eq("R1", "pos_valid", pos_valid, 0);
        check_eq("R1", "x_pos", x_pos, 0);
        check_eq("R1", "y_pos", y_pos, 0);
        repeat (40) @(negedge clk);
        check_eq("R1", "cs_n idle with pen up", cs_n, 1);
        check_eq("R1", "no valid while idle", vcount, 0);
    endtask

    // R2 R4 R5 R6 R8: one full scan with given converter values
    task automatic t_scan(input logic [11:0] xa, input logic [11:0] ya);
        int v0;
        xv = xa; yv = ya;
        v0 = vcount;
        pen_n = 1'b0;
        @(negedge clk);
        check_eq("R2", "cs_n low one cycle after pen", cs_n, 0);
        wait_valid("R8");
        check_eq("R5", "x_pos", x_pos, xa);
        check_eq("R5", "y_pos", y_pos, ya);
        check_eq("R8", "cs_n high at valid", cs_n, 1);
        pen_n = 1'b1;
        @(negedge clk);
        check_eq("R8", "valid is one cycle", pos_valid, 0);
        check_frame_shape();
        wait_released();
        check_eq("R8", "one pulse per scan", vcount - v0, 1);
        check_eq("R8", "no wide pulse", v_wide, 0);
    endtask

    // R7: pen bounces during the X frame, scan still completes
    task automatic t_bounce();
        xv = 12'h5A5; yv = 12'hA5A;
        pen_n = 1'b0;
        while (n_rise < 4 || cs_n) @(negedge clk);
        pen_n = 1'b1;
        repeat (40) @(negedge clk);
        pen_n = 1'b0;
        wait_valid("R7");
        check_eq("R7", "x_pos after bounce", x_pos, 12'h5A5);
        check_eq("R7", "y_pos after bounce", y_pos, 12'hA5A);
        check_eq("R7", "rises after bounce", n_rise, 48);
        pen_n = 1'b1;
        wait_released();
    endtask

    // R7 R8: pen lifts during the Y frame, pair discarded
    task automatic t_lift();
        int v0;
        logic [11:0] xp, yp;
        xp = x_pos; yp = y_pos;
        v0 = vcount;
        xv = 12'h111; yv = 12'h222;
        pen_n = 1'b0;
        while (n_rise < 30 || cs_n) @(negedge clk);
        pen_n = 1'b1;
        while (!cs_n) @(negedge clk);
        repeat (20) @(negedge clk);
        check_eq("R7", "frame completed after lift", n_rise, 48);
        check_eq("R8", "no valid after lift", vcount - v0, 0);
        check_eq("R8", "x_pos kept", x_pos, xp);
        check_eq("R8", "y_pos kept", y_pos, yp);
    endtask

    // R9: pen held down, back-to-back scans with the rest gap
    task automatic t_repeat();
        xv = 12'h3C3; yv = 12'hC3C;
        pen_n = 1'b0;
        wait_valid("R9");
        check_eq("R9", "first x", x_pos, 12'h3C3);
        xv = 12'h0F0; yv = 12'hF0F;
        wait_valid("R9");
        pen_n = 1'b1;
        check_eq("R9", "cs_n high time between scans", last_rest, P_REST + 1);
        check_eq("R9", "second x", x_pos, 12'h0F0);
        check_eq("R9", "second y", y_pos, 12'hF0F);
        check_frame_shape();
        wait_released();
    endtask

    initial begin
        bit wd_hit = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        fork
            begin
                t_reset();
                t_scan(12'hABC, 12'h123);
                t_scan(12'h000, 12'hFFF);
                t_scan(12'h801, 12'h7FE);
                t_bounce();
                t_lift();
                t_repeat();
            end
            begin
                repeat (100000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=expired expected=completed");
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule